// File: doc/BRIEF.md
# Mailbox Link Reset Handshake Sequencer

This block runs the reset negotiation of an inter-processor mailbox link toward a security peer. Three flag bits pass between the two sides: a phase-one flag (ENTRY), a phase-two flag (EXIT) and a query flag (QUERY). The block writes flags to the peer through an outgoing control register. It watches an incoming control register whose bits are cleared by writing ones. Each poll classifies the incoming value, acknowledges it with a write-1-to-clear mask and answers with a new outgoing flag. The exit phase also clears the incoming doorbell and the register-valid flags, in a fixed order.

A start pulse begins the handshake. When the link is not in secure mode, nothing is negotiated and completion is reported at once. Polls are spaced by a programmable cycle count. After the exit answer, the block waits a programmable settle time and reads the incoming register again. A stale QUERY at that point sends it back into the loop. A budget of polls bounds the whole exchange, and a timeout is reported when the budget runs out.

Top module: `mbrst_handshake`

## Requirements
- R1: When `start_i` is seen while idle with `secure_i` low, `done_o` pulses on the next cycle. No register write is issued and `busy_o` stays low.
- R2: When `start_i` is seen while idle with `secure_i` high, the block first issues one incoming clear whose mask equals the incoming value at that moment. It then writes ENTRY (bit 4, value 0x10) to the outgoing register.
- R3: A poll that reads exactly ENTRY|EXIT (0x30), or that value with QUERY (bit 6), clears mask 0x30 and then writes QUERY (0x40) outward.
- R4: A poll that reads exactly ENTRY (0x10) or ENTRY|QUERY (0x50) clears mask 0x50 and then writes ENTRY outward.
- R5: A poll that reads exactly QUERY (0x40) clears mask 0x40 and then writes ENTRY outward.
- R6: A poll that reads exactly EXIT (bit 5, 0x20) or EXIT|QUERY (0x60) runs four steps in this order: clear 0x20; clear the doorbell; clear 0x47 (valid-assert bit 0, valid-deassert bit 1, valid-ack bit 2, and QUERY); write EXIT (0x20) outward.
- R7: After the exit write and `settle_cycles_i`+1 idle cycles, the incoming register is read again. If QUERY is clear, `done_o` pulses. If QUERY is set, polling resumes.
- R8: Any other incoming value at a poll, including one with extra bits set beside the flags, causes no write of any kind.
- R9: Consecutive polls of an ignored value are `poll_cycles_i`+3 cycles apart. With every poll ignored, `timeout_o` rises MAX_POLLS*(`poll_cycles_i`+3)+1 cycles after the initial ENTRY write.
- R10: The budget counts polls. An exit that completes on the last budgeted poll reports done and no timeout. A QUERY still set at that recheck reports timeout and no done.
- R11: `busy_o` is high from an accepted secure start until the cycle `done_o` or `timeout_o` pulses. Those pulses last one cycle, and `start_i` has no effect while busy.
- R12: At most one of the incoming clear, doorbell clear and outgoing write strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a handshake (sampled while idle) |
| secure_i | input | 1 | Secure mode; low skips the handshake |
| poll_cycles_i | input | CNT_W | Wait between polls, in cycles |
| settle_cycles_i | input | CNT_W | Wait before the post-exit reread |
| csr_in_i | input | CSR_W | Current incoming control register value |
| in_clr_o | output | 1 | Write-1-to-clear strobe for the incoming register |
| in_clr_mask_o | output | CSR_W | Bits cleared by that strobe |
| db_clr_o | output | 1 | Strobe writing zero to the incoming doorbell |
| out_we_o | output | 1 | Write strobe for the outgoing register |
| out_data_o | output | CSR_W | Value written to the outgoing register |
| busy_o | output | 1 | Handshake in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle budget-exhausted pulse |

## Verification
Two functions can act in the same cycle: exit completion and budget exhaustion, when EXIT first appears on the last poll the budget allows. The bench presents an all-zero incoming value until the second-to-last poll has passed, then switches to EXIT just before the final poll. The run passes when done is reported and timeout is not. The same timing is repeated with EXIT|QUERY held, which keeps QUERY set at the recheck. That run passes only if timeout is reported and done is not.

// File: rtl/mbrst_pkg.sv
package mbrst_pkg;
  localparam int unsigned VREQ_SET_BIT = 0;
  localparam int unsigned VREQ_CLR_BIT = 1;
  localparam int unsigned VACK_BIT     = 2;
  localparam int unsigned ENTRY_BIT    = 4;
  localparam int unsigned EXIT_BIT     = 5;
  localparam int unsigned QUERY_BIT    = 6;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_TO_QUERY,
    ACT_TO_ENTRY,
    ACT_EXIT
  } act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT_CLR,
    ST_INIT_ENTRY,
    ST_WAIT,
    ST_SAMPLE,
    ST_CLR_A,
    ST_DB,
    ST_CLR_B,
    ST_OUT,
    ST_SETTLE,
    ST_RECHECK,
    ST_NEXT
  } st_e;
endpackage

// File: rtl/mbrst_decode.sv
module mbrst_decode
  import mbrst_pkg::*;
#(
  parameter int unsigned CSR_W = 8
) (
  input  logic [CSR_W-1:0] csr_i,
  output act_e             act_o,
  output logic [CSR_W-1:0] mask_o,
  output logic [CSR_W-1:0] out_o
);
  localparam logic [CSR_W-1:0] M_E = CSR_W'(1) << ENTRY_BIT;
  localparam logic [CSR_W-1:0] M_X = CSR_W'(1) << EXIT_BIT;
  localparam logic [CSR_W-1:0] M_Q = CSR_W'(1) << QUERY_BIT;

  // exact-value match: any extra bit makes the value unrecognised
  always_comb begin
    act_o  = ACT_NONE;
    mask_o = '0;
    out_o  = '0;
    if (csr_i == (M_E | M_X) || csr_i == (M_E | M_X | M_Q)) begin
      act_o  = ACT_TO_QUERY;
      mask_o = M_E | M_X;
      out_o  = M_Q;
    end else if (csr_i == M_E || csr_i == (M_E | M_Q)) begin
      act_o  = ACT_TO_ENTRY;
      mask_o = M_E | M_Q;
      out_o  = M_E;
    end else if (csr_i == M_Q) begin
      act_o  = ACT_TO_ENTRY;
      mask_o = M_Q;
      out_o  = M_E;
    end else if (csr_i == M_X || csr_i == (M_X | M_Q)) begin
      act_o  = ACT_EXIT;
      mask_o = M_X;
      out_o  = M_X;
    end
  end
endmodule

// File: rtl/mbrst_timer.sv
module mbrst_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mbrst_budget.sv
module mbrst_budget #(
  parameter int unsigned MAX_POLLS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int unsigned BUD_W = $clog2(MAX_POLLS + 1);
  localparam logic [BUD_W-1:0] LIMIT = BUD_W'(MAX_POLLS);

  logic [BUD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != LIMIT) cnt_q <= cnt_q + BUD_W'(1);
  end

  assign spent_o = (cnt_q == LIMIT);
endmodule

// File: rtl/mbrst_handshake.sv
module mbrst_handshake
  import mbrst_pkg::*;
#(
  parameter int unsigned CSR_W     = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MAX_POLLS = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             secure_i,
  input  logic [CNT_W-1:0] poll_cycles_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  input  logic [CSR_W-1:0] csr_in_i,
  output logic             in_clr_o,
  output logic [CSR_W-1:0] in_clr_mask_o,
  output logic             db_clr_o,
  output logic             out_we_o,
  output logic [CSR_W-1:0] out_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam logic [CSR_W-1:0] M_E = CSR_W'(1) << ENTRY_BIT;
  localparam logic [CSR_W-1:0] M_Q = CSR_W'(1) << QUERY_BIT;
  localparam logic [CSR_W-1:0] M_VALID_Q = (CSR_W'(1) << VREQ_SET_BIT)
                                         | (CSR_W'(1) << VREQ_CLR_BIT)
                                         | (CSR_W'(1) << VACK_BIT) | M_Q;

  st_e              st_q, st_d;
  act_e             act_q, act_d, dec_act;
  logic [CSR_W-1:0] mask_q, mask_d, oval_q, oval_d, dec_mask, dec_out;
  logic             busy_q, busy_d, done_q, done_d, to_q, to_d;
  logic             tmr_load, tmr_exp, bud_clr, bud_inc, bud_spent;
  logic [CNT_W-1:0] tmr_val;

  mbrst_decode #(.CSR_W(CSR_W)) u_dec (
    .csr_i  (csr_in_i),
    .act_o  (dec_act),
    .mask_o (dec_mask),
    .out_o  (dec_out)
  );

  mbrst_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  mbrst_budget #(.MAX_POLLS(MAX_POLLS)) u_bud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bud_clr),
    .inc_i   (bud_inc),
    .spent_o (bud_spent)
  );

  always_comb begin
    st_d     = st_q;
    act_d    = act_q;
    mask_d   = mask_q;
    oval_d   = oval_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    to_d     = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = poll_cycles_i;
    bud_clr  = 1'b0;
    bud_inc  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (secure_i) begin
            st_d   = ST_INIT_CLR;
            busy_d = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_INIT_CLR:   st_d = ST_INIT_ENTRY;
      ST_INIT_ENTRY: begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
        bud_clr  = 1'b1;
      end
      ST_WAIT: if (tmr_exp) st_d = ST_SAMPLE;
      ST_SAMPLE: begin
        bud_inc = 1'b1;
        act_d   = dec_act;
        mask_d  = dec_mask;
        oval_d  = dec_out;
        st_d    = (dec_act == ACT_NONE) ? ST_NEXT : ST_CLR_A;
      end
      ST_CLR_A: st_d = (act_q == ACT_EXIT) ? ST_DB : ST_OUT;
      ST_DB:    st_d = ST_CLR_B;
      ST_CLR_B: st_d = ST_OUT;
      ST_OUT: begin
        if (act_q == ACT_EXIT) begin
          st_d     = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = settle_cycles_i;
        end else begin
          st_d = ST_NEXT;
        end
      end
      ST_SETTLE: if (tmr_exp) st_d = ST_RECHECK;
      ST_RECHECK: begin
        if (csr_in_i[QUERY_BIT]) begin
          st_d = ST_NEXT;
        end else begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
      ST_NEXT: begin
        if (bud_spent) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          to_d   = 1'b1;
        end else begin
          st_d     = ST_WAIT;
          tmr_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      act_q  <= ACT_NONE;
      mask_q <= '0;
      oval_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      mask_q <= mask_d;
      oval_q <= oval_d;
      busy_q <= busy_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  always_comb begin
    in_clr_o      = 1'b0;
    in_clr_mask_o = '0;
    db_clr_o      = (st_q == ST_DB);
    out_we_o      = 1'b0;
    out_data_o    = '0;
    case (st_q)
      ST_INIT_CLR: begin in_clr_o = 1'b1; in_clr_mask_o = csr_in_i;  end
      ST_CLR_A:    begin in_clr_o = 1'b1; in_clr_mask_o = mask_q;    end
      ST_CLR_B:    begin in_clr_o = 1'b1; in_clr_mask_o = M_VALID_Q; end
      ST_INIT_ENTRY: begin out_we_o = 1'b1; out_data_o = M_E;    end
      ST_OUT:        begin out_we_o = 1'b1; out_data_o = oval_q; end
      default: ;
    endcase
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/mbrst_handshake_chk.sv
module mbrst_handshake_chk
  import mbrst_pkg::*;
#(
  parameter int unsigned CSR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             secure_i,
  input logic             in_clr_o,
  input logic [CSR_W-1:0] in_clr_mask_o,
  input logic             db_clr_o,
  input logic             out_we_o,
  input logic [CSR_W-1:0] out_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             timeout_o
);
  localparam logic [CSR_W-1:0] M_E = CSR_W'(1) << ENTRY_BIT;
  localparam logic [CSR_W-1:0] M_X = CSR_W'(1) << EXIT_BIT;
  localparam logic [CSR_W-1:0] M_Q = CSR_W'(1) << QUERY_BIT;
  localparam logic [CSR_W-1:0] M_VQ = (CSR_W'(1) << VREQ_SET_BIT)
                                    | (CSR_W'(1) << VREQ_CLR_BIT)
                                    | (CSR_W'(1) << VACK_BIT) | M_Q;

  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_clr_o, db_clr_o, out_we_o})); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(in_clr_o || db_clr_o || out_we_o)); // R1
  AST_NONSECURE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !secure_i) |=> (done_o && !busy_o)); // R1
  AST_SECURE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && secure_i) |=> (busy_o && in_clr_o)); // R2
  AST_DB_AFTER_EXIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_clr_o |-> ($past(in_clr_o) && $past(in_clr_mask_o) == M_X)); // R6
  AST_VALID_CLR_AFTER_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_clr_o |=> (in_clr_o && in_clr_mask_o == M_VQ)); // R6
  AST_OUT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> (out_data_o == M_E || out_data_o == M_X || out_data_o == M_Q)); // R3
endmodule

bind mbrst_handshake mbrst_handshake_chk #(.CSR_W(CSR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .secure_i      (secure_i),
  .in_clr_o      (in_clr_o),
  .in_clr_mask_o (in_clr_mask_o),
  .db_clr_o      (db_clr_o),
  .out_we_o      (out_we_o),
  .out_data_o    (out_data_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .timeout_o     (timeout_o)
);

// File: tb/sim_mbrst_handshake.sv
`timescale 1ns/1ps
module sim_mbrst_handshake;
  localparam int unsigned CSR_W = 8;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned MAXP  = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             secure_i = 1'b1;
  logic [CNT_W-1:0] poll_cycles_i = 16'd20;
  logic [CNT_W-1:0] settle_cycles_i = 16'd2;
  logic [CSR_W-1:0] csr_in_i = '0;
  logic             in_clr_o, db_clr_o, out_we_o, busy_o, done_o, timeout_o;
  logic [CSR_W-1:0] in_clr_mask_o, out_data_o;

  always #10 clk = ~clk;

  mbrst_handshake #(.CSR_W(CSR_W), .CNT_W(CNT_W), .MAX_POLLS(MAXP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .secure_i(secure_i),
    .poll_cycles_i(poll_cycles_i), .settle_cycles_i(settle_cycles_i),
    .csr_in_i(csr_in_i), .in_clr_o(in_clr_o), .in_clr_mask_o(in_clr_mask_o),
    .db_clr_o(db_clr_o), .out_we_o(out_we_o), .out_data_o(out_data_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int ev_n, done_cnt, to_cnt, done_cyc, to_cyc;
  logic busy_seen;
  int ev_kind [32];
  int ev_val  [32];
  int ev_cyc  [32];

  always @(posedge clk) cyc <= cyc + 1;

  // event monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ev_n < 32) begin
        if (in_clr_o) begin ev_kind[ev_n] = 1; ev_val[ev_n] = int'(in_clr_mask_o); ev_cyc[ev_n] = cyc; ev_n++; end
        else if (db_clr_o) begin ev_kind[ev_n] = 2; ev_val[ev_n] = 0; ev_cyc[ev_n] = cyc; ev_n++; end
        else if (out_we_o) begin ev_kind[ev_n] = 3; ev_val[ev_n] = int'(out_data_o); ev_cyc[ev_n] = cyc; ev_n++; end
      end
      if (done_o) begin done_cnt++; done_cyc = cyc; end
      if (timeout_o) begin to_cnt++; to_cyc = cyc; end
      if (busy_o) busy_seen = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    start_i = 1'b0;
    tick(2);
    ev_n = 0; done_cnt = 0; to_cnt = 0; done_cyc = 0; to_cyc = 0; busy_seen = 1'b0;
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic wait_entry();
    for (int i = 0; i < 50 && ev_n < 2; i++) tick(1);
  endtask

  typedef struct packed {
    logic [7:0] csr;
    logic [7:0] m1;
    logic [7:0] m2;
    logic [7:0] ov;
    logic [2:0] nev;
    logic       dn;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{8'h30, 8'h30, 8'h00, 8'h40, 3'd2, 1'b0},  // R3
    '{8'h70, 8'h30, 8'h00, 8'h40, 3'd2, 1'b0},  // R3
    '{8'h10, 8'h50, 8'h00, 8'h10, 3'd2, 1'b0},  // R4
    '{8'h50, 8'h50, 8'h00, 8'h10, 3'd2, 1'b0},  // R4
    '{8'h40, 8'h40, 8'h00, 8'h10, 3'd2, 1'b0},  // R5
    '{8'h20, 8'h20, 8'h47, 8'h20, 3'd4, 1'b1},  // R6 R7
    '{8'h60, 8'h20, 8'h47, 8'h20, 3'd4, 1'b0},  // R6 R7
    '{8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0},  // R8
    '{8'h11, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0},  // R8
    '{8'h08, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0}   // R8
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    // reset state: R11 R12
    chk("R11", "busy after reset", int'(busy_o), 0);
    chk("R11", "done/timeout after reset", int'(done_o | timeout_o), 0);
    chk("R12", "strobes after reset", int'(in_clr_o | db_clr_o | out_we_o), 0);

    // table walk: one poll per vector
    poll_cycles_i = 16'd20;
    settle_cycles_i = 16'd2;
    for (int v = 0; v < 10; v++) begin
      do_reset();
      secure_i = 1'b1;
      csr_in_i = '0;
      pulse_start();
      wait_entry();
      csr_in_i = TBL[v].csr;
      tick(34);
      chk("R3-R8 vec", $sformatf("event count csr=%0h", TBL[v].csr), ev_n, 2 + int'(TBL[v].nev));
      if (TBL[v].nev == 3'd2 && ev_n >= 4) begin
        chk("R3 R4 R5", "clear", ev_val[2] | (ev_kind[2] << 8), int'(TBL[v].m1) | (1 << 8));
        chk("R3 R4 R5", "out", ev_val[3] | (ev_kind[3] << 8), int'(TBL[v].ov) | (3 << 8));
      end
      if (TBL[v].nev == 3'd4 && ev_n >= 6) begin
        chk("R6", "exit clear", ev_val[2] | (ev_kind[2] << 8), int'(TBL[v].m1) | (1 << 8));
        chk("R6", "doorbell", ev_kind[3], 2);
        chk("R6", "valid clear", ev_val[4] | (ev_kind[4] << 8), int'(TBL[v].m2) | (1 << 8));
        chk("R6", "exit out", ev_val[5] | (ev_kind[5] << 8), int'(TBL[v].ov) | (3 << 8));
      end
      chk("R7", $sformatf("done count csr=%0h", TBL[v].csr), done_cnt, int'(TBL[v].dn));
      chk("R11", "busy level", int'(busy_o), TBL[v].dn ? 0 : 1);
    end

    // R1: non-secure start
    do_reset();
    secure_i = 1'b0;
    pulse_start();
    tick(3);
    chk("R1", "done pulses", done_cnt, 1);
    chk("R1", "no writes", ev_n, 0);
    chk("R1", "busy never high", int'(busy_seen), 0);
    secure_i = 1'b1;

    // R2: initial clear uses current incoming value
    do_reset();
    csr_in_i = 8'h37;
    pulse_start();
    tick(1);
    wait_entry();
    chk("R2", "init clear mask", ev_val[0] | (ev_kind[0] << 8), 8'h37 | (1 << 8));
    chk("R2", "init entry write", ev_val[1] | (ev_kind[1] << 8), 8'h10 | (3 << 8));
    csr_in_i = '0;

    // R7: QUERY at recheck loops, then completes once it clears
    do_reset();
    csr_in_i = '0;
    pulse_start();
    wait_entry();
    csr_in_i = 8'h60;
    tick(34);
    chk("R7", "no done while QUERY stays", done_cnt, 0);
    chk("R7", "still busy", int'(busy_o), 1);
    csr_in_i = 8'h20;
    tick(60);
    chk("R7", "done after QUERY clears", done_cnt, 1);
    chk("R7", "idle after done", int'(busy_o), 0);

    // R9 R10 R11: budget exhausted, start ignored while busy
    poll_cycles_i = 16'd2;
    do_reset();
    csr_in_i = '0;
    pulse_start();
    wait_entry();
    base = ev_cyc[1];
    tick(8);
    pulse_start();
    tick(40);
    chk("R11", "start while busy ignored", ev_n, 2);
    chk("R10", "one timeout", to_cnt, 1);
    chk("R10", "no done", done_cnt, 0);
    chk("R9", "timeout cycle offset", to_cyc - base, int'(MAXP) * (2 + 3) + 1);
    chk("R11", "busy cleared", int'(busy_o), 0);

    // R10: exit on the last budgeted poll completes
    do_reset();
    csr_in_i = '0;
    pulse_start();
    wait_entry();
    base = ev_cyc[1];
    while (cyc < base + 26) tick(1);
    csr_in_i = 8'h20;
    tick(30);
    chk("R10", "final-poll exit done", done_cnt, 1);
    chk("R10", "final-poll exit no timeout", to_cnt, 0);

    // R10: QUERY kept at the final recheck times out
    do_reset();
    csr_in_i = '0;
    pulse_start();
    wait_entry();
    base = ev_cyc[1];
    while (cyc < base + 26) tick(1);
    csr_in_i = 8'h60;
    tick(30);
    chk("R10", "final-poll query timeout", to_cnt, 1);
    chk("R10", "final-poll query no done", done_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule